// File: doc/BRIEF.md
# Interrupt Recognition and Priority Arbiter

This block sits beside the instruction sequencer of a small 8-bit processor core. It samples three active-low request lines: a reset request, a non-maskable request and a maskable request. At each instruction boundary it decides whether the next opcode fetch is replaced by the break opcode `$00`. When a request is accepted, the opcode register is loaded with `$00` instead of the byte read from memory. A single break routine then serves every interrupt source. The break routine learns which source it serves from a latched one-hot code, and it reads the break flag value to push with the status byte.

The winning source is resolved by fixed priority: reset first, then non-maskable, then maskable. The maskable request is gated by the interrupt-disable flag. Recognition is held back by one instruction when the instruction that just ended was a short taken branch, meaning three cycles with no page crossing. A `$00` byte fetched from memory with no external line active is reported as a software break, with the break flag value set. The latched source code stays stable until the entry sequencer reports completion.

Top module: `intr_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `force_brk`, `brk_bit` and `src_code` go to zero and `opcode_q` goes to `8'h00`.
- R2: The request lines are active-low. When all three are high, a boundary loads `opcode_q` with `mem_opcode` and leaves `force_brk` low.
- R3: `src_code` is one-hot, with bit 3 for reset, bit 2 for non-maskable, bit 1 for maskable and bit 0 for software break. When requests arrive together, reset wins over non-maskable, and non-maskable wins over maskable.
- R4: While `irq_mask` is high, a low `irq_n` is not accepted. Low `res_n` and low `nmi_n` are accepted whatever the value of `irq_mask`.
- R5: An accepted request at a boundary edge loads `opcode_q` with `8'h00`. At the same edge it raises `force_brk` for exactly one cycle and latches the winner into `src_code`.
- R6: Request lines pass through one register stage. A line must be low at the edge before the boundary edge to count at that boundary.
- R7: A boundary with `short_branch` high accepts no external request and loads `mem_opcode`. A request that is still present is accepted at the next boundary that has `short_branch` low.
- R8: With no source latched, a boundary that accepts nothing and fetches `8'h00` latches `src_code = 4'b0001`. `brk_bit` is set only if none of the three sampled lines is low; a masked maskable line still counts as low.
- R9: `brk_bit` is zero whenever an external request is accepted.
- R10: Once `src_code` is nonzero it holds through later boundaries and request changes. It and `brk_bit` clear at the edge where `entry_done` is high.
- R11: At an edge with `at_boundary` low, `opcode_q` keeps its value and `force_brk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_n | input | 1 | Reset request, active-low |
| nmi_n | input | 1 | Non-maskable request, active-low |
| irq_n | input | 1 | Maskable request, active-low |
| irq_mask | input | 1 | Interrupt-disable flag |
| at_boundary | input | 1 | Opcode fetch cycle of the next instruction |
| short_branch | input | 1 | The instruction that just ended was a taken branch with no page crossing |
| mem_opcode | input | 8 | Opcode byte read from memory |
| entry_done | input | 1 | The entry sequencer has finished |
| force_brk | output | 1 | One-cycle pulse: break opcode injected |
| opcode_q | output | 8 | Opcode register |
| src_code | output | 4 | Latched one-hot source code {reset, nmi, irq, brk} |
| brk_bit | output | 1 | Break flag value to push |

## Verification
The main sweep tries every combination of the three request lines, both mask states, both short-branch states, and a fetched opcode of either `$00` or a non-break byte. Together these separate the priority order, the masking of only the maskable line, and deferral versus immediate acceptance. They also separate a software break with the flag set from a `$00` fetch that happens while a masked line is low. For each accepted case, a further boundary while the source is latched shows that the code is held, and a completion pulse shows that it clears. Dedicated patterns cover a line that falls in the boundary cycle itself, which tests the sampling stage, and a change of opcode with no boundary, which tests the hold of the opcode register.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int SRC_W = 4;
  localparam int EXT_N = 3;
  typedef logic [SRC_W-1:0] src_t;
  localparam src_t SRC_NONE = 4'b0000;
  localparam src_t SRC_BRK  = 4'b0001;
  localparam src_t SRC_IRQ  = 4'b0010;
  localparam src_t SRC_NMI  = 4'b0100;
  localparam src_t SRC_RES  = 4'b1000;
endpackage

// File: rtl/req_sampler.sv
// Converts active-low request lines to active-high and registers them.
module req_sampler #(
  parameter int N      = 3,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_n,
  output logic [N-1:0] req_q
);
  for (genvar s = 0; s < N; s++) begin : g_src
    logic [STAGES-1:0] chain;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= ~line_n[s];
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], ~line_n[s]};
      end
    end
    assign req_q[s] = chain[STAGES-1];
  end
endmodule

// File: rtl/prio_pick.sv
// Fixed-priority selector: the highest index wins, and the output is one-hot.
module prio_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k]) begin
        grant    = '0;
        grant[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int          OPW         = 8,
  parameter logic [7:0]  BRK_OPCODE  = 8'h00,
  parameter int          SYNC_STAGES = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           res_n,
  input  logic           nmi_n,
  input  logic           irq_n,
  input  logic           irq_mask,
  input  logic           at_boundary,
  input  logic           short_branch,
  input  logic [OPW-1:0] mem_opcode,
  input  logic           entry_done,
  output logic           force_brk,
  output logic [OPW-1:0] opcode_q,
  output logic [SRC_W-1:0] src_code,
  output logic           brk_bit
);
  localparam logic [OPW-1:0] BRK_OP = OPW'(BRK_OPCODE);

  logic [EXT_N-1:0] ext_q;     // {res, nmi, irq}, active-high
  logic [EXT_N-1:0] eligible;
  logic [EXT_N-1:0] grant;
  src_t             winner;
  logic             busy, take, any_line, soft_brk;

  req_sampler #(.N(EXT_N), .STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst),
    .line_n({res_n, nmi_n, irq_n}),
    .req_q(ext_q)
  );

  assign eligible = {ext_q[2], ext_q[1], ext_q[0] & ~irq_mask};

  prio_pick #(.N(EXT_N)) u_pick (.req(eligible), .grant(grant));

  assign winner   = {grant, 1'b0};
  assign busy     = (src_code != SRC_NONE);
  assign any_line = |ext_q;
  assign take     = at_boundary & ~short_branch & ~busy & (|eligible);
  assign soft_brk = at_boundary & ~take & ~busy & (mem_opcode == BRK_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      force_brk <= 1'b0;
      opcode_q  <= '0;
      src_code  <= SRC_NONE;
      brk_bit   <= 1'b0;
    end else begin
      force_brk <= take;
      if (at_boundary) opcode_q <= take ? BRK_OP : mem_opcode;
      if (take) begin
        src_code <= winner;
        brk_bit  <= 1'b0;
      end else if (soft_brk) begin
        src_code <= SRC_BRK;
        brk_bit  <= ~any_line;
      end else if (busy && entry_done) begin
        src_code <= SRC_NONE;
        brk_bit  <= 1'b0;
      end
    end
  end

  // R3: at most one source is reported
  a_r3_onehot_src: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_code));
  // R5: an injected break leaves the break opcode in the opcode register
  a_r5_force_loads_brk: assert property (@(posedge clk) disable iff (rst)
    force_brk |-> (opcode_q == BRK_OP) && (src_code != SRC_NONE) && (src_code != SRC_BRK));
  // R5: the force pulse lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    force_brk |=> !force_brk);
  // R4: a maskable source is never taken while the mask was set
  a_r4_mask_respected: assert property (@(posedge clk) disable iff (rst)
    (at_boundary && irq_mask && !ext_q[2] && !ext_q[1]) |=> !force_brk);
  // R9: the break flag accompanies only a software break
  a_r9_brk_only_soft: assert property (@(posedge clk) disable iff (rst)
    brk_bit |-> (src_code == SRC_BRK));
  // R10: a latched source holds until completion
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !entry_done) |=> $stable(src_code));
  // R10: completion clears the source
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (busy && entry_done) |=> (src_code == SRC_NONE));
  // R11: the opcode register holds outside boundaries
  a_r11_hold_opcode: assert property (@(posedge clk) disable iff (rst)
    !at_boundary |=> ($stable(opcode_q) && !force_brk));
endmodule

// File: tb/intr_arbiter_test.sv
module intr_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       res_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1, irq_mask = 1'b0;
  logic       at_boundary = 1'b0, short_branch = 1'b0, entry_done = 1'b0;
  logic [7:0] mem_opcode = 8'hEA;
  logic       force_brk, brk_bit;
  logic [7:0] opcode_q;
  logic [3:0] src_code;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  intr_arbiter uut (
    .clk(clk), .rst(rst), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
    .irq_mask(irq_mask), .at_boundary(at_boundary), .short_branch(short_branch),
    .mem_opcode(mem_opcode), .entry_done(entry_done), .force_brk(force_brk),
    .opcode_q(opcode_q), .src_code(src_code), .brk_bit(brk_bit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, then move to the next falling edge
  task automatic cyc(input logic b, input logic sb, input logic d, input logic [7:0] op);
    at_boundary  = b;
    short_branch = sb;
    entry_done   = d;
    mem_opcode   = op;
    @(negedge clk);
    at_boundary  = 1'b0;
    short_branch = 1'b0;
    entry_done   = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 force", force_brk, 0);
    chk("R1 src", src_code, 0);
    chk("R1 brk", brk_bit, 0);
    chk("R1 opcode", opcode_q, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 8'hEA);

    // R2: idle lines, plain fetch
    cyc(1, 0, 0, 8'hA9);
    chk("R2 opcode", opcode_q, 8'hA9);
    chk("R2 force", force_brk, 0);
    chk("R2 src", src_code, 0);

    // R11: no boundary, opcode held
    cyc(0, 0, 0, 8'h55);
    chk("R11 opcode hold", opcode_q, 8'hA9);
    chk("R11 force", force_brk, 0);

    // R6: line falls in the boundary cycle itself and is not yet seen
    nmi_n = 1'b0;
    cyc(1, 0, 0, 8'h18);
    chk("R6 late line not taken", force_brk, 0);
    chk("R6 opcode", opcode_q, 8'h18);
    cyc(1, 0, 0, 8'h38);
    chk("R6 taken next boundary", force_brk, 1);
    chk("R6 src", src_code, 4'b0100);
    cyc(0, 0, 1, 8'hEA);
    nmi_n = 1'b1;
    cyc(0, 0, 0, 8'hEA);

    // Sweep every line, mask, short-branch and opcode combination
    for (int v = 0; v < 32; v++) begin
      logic r, n, i, m, sb, take;
      logic [7:0] op;
      logic [3:0] win, exp_src;
      r  = v[0]; n = v[1]; i = v[2]; m = v[3]; sb = v[4];
      for (int o = 0; o < 2; o++) begin
        op = (o == 0) ? 8'h00 : 8'hA9;
        res_n = ~r; nmi_n = ~n; irq_n = ~i; irq_mask = m;
        cyc(0, 0, 0, 8'hEA);          // let the sampling stage capture (R6)
        win  = r ? 4'b1000 : n ? 4'b0100 : (i && !m) ? 4'b0010 : 4'b0000;
        take = !sb && (win != 0);
        exp_src = take ? win : ((op == 8'h00) ? 4'b0001 : 4'b0000);
        cyc(1, sb, 0, op);
        chk("R3/R4/R7 force", force_brk, take);
        chk("R5/R7 opcode", opcode_q, take ? 8'h00 : op);
        chk("R3/R8 src", src_code, exp_src);
        chk("R8/R9 brk", brk_bit, (!take && op == 8'h00 && !(r || n || i)));
        if (sb && win != 0 && exp_src == 0) begin
          // R7: deferred request is taken one instruction later
          cyc(1, 0, 0, 8'hEA);
          chk("R7 deferred take", force_brk, 1);
          chk("R7 deferred src", src_code, win);
          exp_src = win;
        end
        if (exp_src != 0) begin
          // R10: held across another boundary with a fresh break fetch
          cyc(1, 0, 0, 8'h00);
          chk("R10 held", src_code, exp_src);
          chk("R10 no new force", force_brk, 0);
          cyc(0, 0, 1, 8'hEA);
          chk("R10 cleared", src_code, 0);
          chk("R10 brk cleared", brk_bit, 0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule